// File: doc/BRIEF.md
# Dual-Mode Synchronous Serial Port

This block moves one byte at a time over a clocked serial link. A control register selects the wiring (separate data-in and data-out lines, or a single shared data line), the bit order, whether the block makes the shift clock itself or follows a clock from outside, and, when it makes the clock, which of six rates to use. Software loads the byte to send, pulses `start`, and waits for the interrupt flag. Once the flag is set, the received byte can be read on `rx_data`.

In master mode a divider on the system clock makes the shift clock. The divider assumes a 4.5 MHz system clock, so the six rates run from 12.5 kHz to 450 kHz. In slave mode the clock pin is an input, and its transitions pass through a two-flop synchronizer. Transmit data changes on the falling shift-clock edge. Receive data is sampled on the rising edge. The clock idles high.

Top module: `sio_port`

## Requirements
- R1: After reset, `busy`, `irq` and `sck_oe` are 0, `sck_o`, `sdo` and `sdo_oe` are 1, `rx_data` is 0x00, and the control register is 0x00 (3-wire, MSB first, slave, rate code 0).
- R2: A `start` pulse while idle sets `busy`. Each transfer has exactly 8 rising shift-clock edges. `busy` falls on the eighth, and `rx_data` then holds the received byte.
- R3: Control bit 1 selects the bit order for both transmit and receive: 1 sends and receives bit 0 first, 0 sends and receives bit 7 first.
- R4: In master mode the full shift-clock period, in system clocks, is 360, 120, 24, 16, 12 or 10 for rate codes 0 to 5 (control bits 6:4). Codes 6 and 7 act as code 0. `sck_o` is high whenever `busy` is low.
- R5: `sdo` changes only after a falling shift-clock edge. The input bit is taken at each rising edge.
- R6: Control bit 2 = 1 selects master mode, with `sck_oe` = 1. In slave mode `sck_oe` = 0 and the block shifts on `sck_i` edges after a two-flop synchronizer.
- R7: Control bit 0 = 1 selects 2-wire mode. In 2-wire mode the input bit comes from `sdio_i` and `sdo_oe` equals control bit 3 (1 = transmit). In 3-wire mode the input comes from `si_i` and `sdo_oe` is 1.
- R8: While `busy` is high, writes to the data register, writes to the control register and `start` pulses have no effect.
- R9: `irq` is set when a transfer completes and stays set until `irq_clr` is pulsed. If both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4.5 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control value: [0] 2-wire, [1] LSB first, [2] master, [3] 2-wire transmit, [6:4] rate |
| dat_we | input | 1 | Transmit data write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| start | input | 1 | Begin a transfer |
| irq_clr | input | 1 | Clear the completion flag |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt request |
| rx_data | output | 8 | Received byte |
| sck_o | output | 1 | Shift clock out (master) |
| sck_oe | output | 1 | Shift clock pin drive enable |
| sck_i | input | 1 | External shift clock (slave) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data-out drive enable |
| si_i | input | 1 | Serial data in (3-wire) |
| sdio_i | input | 1 | Shared data line input (2-wire) |

## Verification
The bench sweeps all eight master rate codes in 3-wire mode and alternates the bit order across the sweep. This separates the six divide ratios, checks that codes 6 and 7 fall back to code 0, and shows whether the data is reversed. In 2-wire mode the unused data input is driven with the inverse of the wanted bit, so the bench can tell which input pin the block sampled, and it covers both transmit and receive direction. A transfer with a data write, a control write and a second start injected mid-byte shows that none of them disturbs the bits sent, the clock period or the edge count. Slave transfers in both bit orders cover the synchronized external clock.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int DATA_W   = 8;
    localparam int CNT_W    = $clog2(DATA_W);
    localparam int HALF_W   = 8;
    localparam int RATE_W   = 3;
    localparam int CFG_W    = RATE_W + 4;
    localparam int SYNC_STG = 2;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              tx_dir;
        logic              master;
        logic              lsb_first;
        logic              two_wire;
    } sio_cfg_t;

    typedef struct packed {
        logic fall;
        logic rise;
    } sio_evt_t;

    // half of the full shift-clock period, in system clocks
    function automatic logic [HALF_W-1:0] half_period(input logic [RATE_W-1:0] sel);
        case (sel)
            3'd1:    return HALF_W'(60);
            3'd2:    return HALF_W'(12);
            3'd3:    return HALF_W'(8);
            3'd4:    return HALF_W'(6);
            3'd5:    return HALF_W'(5);
            default: return HALF_W'(180);
        endcase
    endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] sel,
    output logic              sck,
    output sio_evt_t          evt
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half;
    logic              wrap;

    assign half = half_period(sel);
    assign wrap = run && (cnt == half - HALF_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            sck <= 1'b1;
        end else if (wrap) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end

    assign evt.fall = wrap && sck;
    assign evt.rise = wrap && !sck;
endmodule

// File: rtl/sio_sck_sync.sv
module sio_sck_sync
    import sio_pkg::*;
#(
    parameter int STAGES = SYNC_STG
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck_in,
    output sio_evt_t evt
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= 1'b1;
        else     pipe[0] <= sck_in;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[g] <= 1'b1;
            else     pipe[g] <= pipe[g-1];
        end
    end

    assign evt.fall = pipe[STAGES] && !pipe[STAGES-1];
    assign evt.rise = !pipe[STAGES] && pipe[STAGES-1];
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              start,
    input  logic              lsb_first,
    input  sio_evt_t          evt,
    input  logic              sin,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] shreg,
    output logic              sout
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] cnt;

    assign done = busy && evt.rise && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            sout  <= 1'b1;
        end else if (!busy) begin
            if (dat_we) shreg <= dat_wdata;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else begin
            if (evt.fall)
                sout <= lsb_first ? shreg[0] : shreg[DATA_W-1];
            if (evt.rise) begin
                shreg <= lsb_first ? {sin, shreg[DATA_W-1:1]}
                                   : {shreg[DATA_W-2:0], sin};
                cnt   <= cnt + CNT_W'(1);
                if (cnt == LAST) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              start,
    input  logic              irq_clr,
    output logic              busy,
    output logic              irq,
    output logic [DATA_W-1:0] rx_data,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              si_i,
    input  logic              sdio_i
);
    sio_cfg_t cfg;
    sio_evt_t gen_evt, ext_evt, evt;
    logic     gen_sck;
    logic     done;
    logic     sin;

    always_ff @(posedge clk) begin
        if (rst)                 cfg <= '0;
        else if (cfg_we && !busy) cfg <= sio_cfg_t'(cfg_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (done)    irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    sio_baud u_baud (
        .clk (clk),
        .rst (rst),
        .run (busy && cfg.master),
        .sel (cfg.rate),
        .sck (gen_sck),
        .evt (gen_evt)
    );

    sio_sck_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .sck_in (sck_i),
        .evt    (ext_evt)
    );

    assign evt = cfg.master ? gen_evt : ext_evt;
    assign sin = cfg.two_wire ? sdio_i : si_i;

    sio_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .start     (start),
        .lsb_first (cfg.lsb_first),
        .evt       (evt),
        .sin       (sin),
        .busy      (busy),
        .done      (done),
        .shreg     (rx_data),
        .sout      (sdo)
    );

    assign sck_o  = cfg.master ? gen_sck : 1'b1;
    assign sck_oe = cfg.master;
    assign sdo_oe = cfg.two_wire ? cfg.tx_dir : 1'b1;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       irq,
    input logic       irq_clr,
    input logic       sck_o,
    input logic       sdo,
    input logic [6:0] cfg_bits
);
    // R2: completion raises the request in the cycle busy drops
    a_r2_done_sets_irq: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    // R4: shift clock idles high
    a_r4_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck_o);

    // R5: data out is steady across a rising shift-clock edge
    a_r5_sdo_steady_on_rise: assert property (@(posedge clk) disable iff (rst)
        (busy && $rose(sck_o)) |-> $stable(sdo));

    // R8: control register frozen during a transfer
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_bits));

    // R9: request held until cleared
    a_r9_irq_held: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);
endmodule

bind sio_port sio_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .irq      (irq),
    .irq_clr  (irq_clr),
    .sck_o    (sck_o),
    .sdo      (sdo),
    .cfg_bits (cfg)
);

// File: tb/sio_port_bench.sv
module sio_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       dat_we = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic       start = 1'b0;
    logic       irq_clr = 1'b0;
    logic       busy, irq, sck_o, sck_oe, sdo, sdo_oe;
    logic [7:0] rx_data;
    logic       sck_i = 1'b1;
    logic       si_i = 1'b0;
    logic       sdio_i = 1'b0;

    int errs = 0;
    int checks = 0;

    always #10 clk = ~clk;

    sio_port u_sio_port (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .start(start), .irq_clr(irq_clr),
        .busy(busy), .irq(irq), .rx_data(rx_data), .sck_o(sck_o), .sck_oe(sck_oe),
        .sck_i(sck_i), .sdo(sdo), .sdo_oe(sdo_oe), .si_i(si_i), .sdio_i(sdio_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 4.5 MHz base over rate in units of 10 Hz
    function automatic int exp_div(input int r);
        int f;
        case (r)
            1: f = 3750;
            2: f = 18750;
            3: f = 28125;
            4: f = 37500;
            5: f = 45000;
            default: f = 1250;
        endcase
        return 450000 / f;
    endfunction

    function automatic logic bit_at(input logic [7:0] v, input int k, input logic lsb);
        return lsb ? v[k] : v[7-k];
    endfunction

    task automatic cfg_write(input logic [6:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic dat_write(input logic [7:0] v);
        @(negedge clk); dat_we = 1'b1; dat_wdata = v;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic xfer_master(input logic [7:0] tx, input logic [7:0] rxp, input int rate,
                               input logic lsb, input logic two, input logic dir,
                               input logic inject);
        int nf, nr, cyc, lim;
        int tf[8];
        logic [7:0] cap;
        logic prev, b;
        cfg_write({rate[2:0], dir, 1'b1, lsb, two});
        dat_write(tx);
        clear_irq();
        @(negedge clk); start = 1'b1;
        nf = 0; nr = 0; cyc = 0; prev = 1'b1; cap = '0;
        lim = exp_div(rate) * 9 + 40;
        @(negedge clk);
        while (cyc < lim) begin
            start = 1'b0; dat_we = 1'b0; cfg_we = 1'b0;
            if (prev && !sck_o) begin
                if (nf < 8) tf[nf] = cyc;
                if (nf == 0) chk("R2 busy during transfer", busy, 1);
                b = (nf < 8) ? bit_at(rxp, nf, lsb) : 1'b0;
                si_i   = two ? ~b : b;
                sdio_i = two ? b : ~b;
                nf++;
            end
            if (!prev && sck_o) begin
                if (nr < 8) cap[lsb ? nr : 7 - nr] = sdo;
                nr++;
                if (inject && nr == 3) begin
                    dat_we = 1'b1; dat_wdata = ~tx;
                    cfg_we = 1'b1; cfg_wdata = {3'd0, ~dir, 1'b0, ~lsb, ~two};
                    start = 1'b1;
                end
            end
            prev = sck_o;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0; dat_we = 1'b0; cfg_we = 1'b0;
        chk("R2 falling edges per byte", nf, 8);
        chk("R2 rising edges per byte", nr, 8);
        chk("R2 idle after byte", busy, 0);
        chk("R2 R9 irq after byte", irq, 1);
        chk("R3 R7 received byte", rx_data, rxp);
        if (!two || dir) chk("R3 R5 transmitted bits", cap, tx);
        chk("R4 first period", tf[1] - tf[0], exp_div(rate));
        chk("R4 last period", tf[7] - tf[6], exp_div(rate));
        chk("R7 data drive enable", sdo_oe, two ? dir : 1'b1);
        chk("R6 master drives clock", sck_oe, 1);
        chk("R4 clock idle high", sck_o, 1);
    endtask

    task automatic xfer_slave(input logic [7:0] tx, input logic [7:0] rxp, input logic lsb);
        logic [7:0] cap;
        logic b;
        cap = '0;
        cfg_write({3'd0, 1'b0, 1'b0, lsb, 1'b0});
        dat_write(tx);
        clear_irq();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            sck_i = 1'b0;
            b = bit_at(rxp, k, lsb);
            si_i = b; sdio_i = ~b;
            repeat (6) @(negedge clk);
            if (k == 7) chk("R6 busy before last slave edge", busy, 1);
            cap[lsb ? k : 7 - k] = sdo;
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
        end
        chk("R6 slave idle after byte", busy, 0);
        chk("R6 slave irq", irq, 1);
        chk("R6 R3 slave received byte", rx_data, rxp);
        chk("R6 R3 slave transmitted bits", cap, tx);
        chk("R6 slave clock pin input", sck_oe, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 irq", irq, 0);
        chk("R1 sck_oe", sck_oe, 0);
        chk("R1 sck_o", sck_o, 1);
        chk("R1 sdo", sdo, 1);
        chk("R1 sdo_oe", sdo_oe, 1);
        chk("R1 rx_data", rx_data, 0);

        for (int r = 0; r < 8; r++)
            xfer_master(8'hA5 ^ 8'(r * 37), 8'h3C + 8'(r * 29), r, r[0], 1'b0, 1'b0, 1'b0);

        xfer_master(8'hC3, 8'h5A, 5, 1'b0, 1'b1, 1'b1, 1'b0);   // R7 2-wire transmit
        xfer_master(8'h0F, 8'h96, 4, 1'b1, 1'b1, 1'b0, 1'b0);   // R7 2-wire receive
        xfer_master(8'h71, 8'hE2, 3, 1'b0, 1'b0, 1'b0, 1'b1);   // R8 mid-byte writes ignored
        chk("R8 control unchanged after ignored write", sdo_oe, 1);

        repeat (20) @(negedge clk);
        chk("R9 irq held", irq, 1);
        clear_irq();
        chk("R9 irq cleared", irq, 0);

        xfer_slave(8'hB4, 8'h2D, 1'b0);
        xfer_slave(8'h61, 8'hD8, 1'b1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule